// File: doc/BRIEF.md
# Timer-Overflow Tone Divider

This block produces a pair of pin-level square waves for a piezo buzzer or any load that needs a steady frequency. It does not count clock cycles itself. It keeps a single toggle state that inverts on every overflow strobe from one of several timer/event counters. A select field picks which timer supplies the strobes. The tone frequency is therefore half the overflow rate of the chosen timer, and that rate is set entirely by the timer's own reload and prescale settings, outside this block.

The two pins carry opposite phases of the toggle state, so they can drive a buzzer differentially. Each pin has its own data bit that works as an on/off gate: a cleared gate holds that pin low. A function-enable bit switches the whole divider on. While it is low, both pins stay low and the toggle state is held at zero. Both pins come straight from registers, so a change of source or gate cannot produce a runt pulse.

Top module: `pfd_tone_gen`

## Requirements
- R1: While reset is asserted, both `pin_o` bits are low and the internal toggle state is zero.
- R2: With `fn_en_i` high, a high `ovf_i[src_sel_i]` sampled at a rising clock edge inverts the toggle state. The new pin levels are visible right after that same edge.
- R3: A strobe on any `ovf_i` bit other than `ovf_i[src_sel_i]` does not change the toggle state or the pins.
- R4: `pin_o[0]` carries the toggle state and `pin_o[1]` carries its inverse. The two pins are never high together.
- R5: If `fn_en_i` is low at a rising edge, both pins are low and the toggle state is zero after that edge. After re-enable, with no strobe, `pin_o[1]` is high and `pin_o[0]` is low.
- R6: If `gate_i[k]` is low at a rising edge, `pin_o[k]` is low after that edge. The toggle state keeps advancing, so when the gate is raised again the pin shows the current phase.
- R7: `src_sel_i` value 0 selects `ovf_i[0]` and value 1 selects `ovf_i[1]`. A new selection applies at the first edge where it is sampled, including to a strobe from the newly chosen timer at that same edge.
- R8: A strobe held high for several consecutive edges counts as one overflow event per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; timer strobes are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_i | input | NUM_SRC | One overflow strobe per timer/event counter |
| src_sel_i | input | SEL_W | Index of the timer whose overflow drives the divider |
| fn_en_i | input | 1 | Divider function enable |
| gate_i | input | 2 | Per-pin data bit; low forces that pin low |
| pin_o | output | 2 | Registered tone outputs; bit 0 true phase, bit 1 inverse phase |

## Verification
The single toggle bit is the only state that is not a direct function of the present inputs. A wrong value in it appears at the pins on the very next edge, as both phases swapped, provided the pin is enabled and gated on. A missed or doubled toggle is therefore caught on the first cycle after the faulty strobe. A wrong clear while disabled shows up as the wrong phase on the first enabled cycle. The bench runs a cycle-accurate model of the toggle and compares both pins after every edge. Random strobe, select, gate and enable patterns are combined with directed cases: select switching, held strobes and re-enable.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int NUM_PINS = 2;

    // Register image of the toggle core
    typedef struct packed {
        logic tgl;
    } tgl_state_t;

    // Register image of the pin stage
    typedef struct packed {
        logic [NUM_PINS-1:0] pins;
    } pin_state_t;

endpackage

// File: rtl/pfd_src_sel.sv
// Picks the overflow strobe of the addressed timer.
module pfd_src_sel #(
    parameter int NUM_SRC = 2,
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] ovf_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               strobe_o
);

    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign hit[s] = ovf_i[s] && (sel_i == SEL_W'(s));
        end
    endgenerate

    // An index with no timer behind it yields no strobe
    assign strobe_o = |hit;

endmodule

// File: rtl/pfd_toggle.sv
// Toggle flip-flop advanced by the selected overflow strobe.
module pfd_toggle
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic strobe_i,
    output logic tgl_d_o,
    output logic tgl_q_o
);

    tgl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.tgl = 1'b0;
        end else if (strobe_i) begin
            st_d.tgl = ~st_q.tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tgl_d_o = st_d.tgl;
    assign tgl_q_o = st_q.tgl;

endmodule

// File: rtl/pfd_pin_gate.sv
// Registered output stage: phase assignment and per-pin gating.
module pfd_pin_gate
    import pfd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                tgl_next_i,
    input  logic [NUM_PINS-1:0] gate_i,
    output logic [NUM_PINS-1:0] pins_o
);

    pin_state_t st_d, st_q;
    logic [NUM_PINS-1:0] phase;

    // Even pins follow the toggle, odd pins follow its inverse
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_phase
            if (p % 2 == 0) begin : g_true
                assign phase[p] = tgl_next_i;
            end else begin : g_inv
                assign phase[p] = ~tgl_next_i;
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            st_d.pins[p] = en_i && gate_i[p] && phase[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pins_o = st_q.pins;

endmodule

// File: rtl/pfd_tone_gen.sv
module pfd_tone_gen
    import pfd_pkg::*;
#(
    parameter int NUM_SRC = 2,
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ovf_i,
    input  logic [SEL_W-1:0]   src_sel_i,
    input  logic               fn_en_i,
    input  logic [1:0]         gate_i,
    output logic [1:0]         pin_o
);

    logic sel_strobe;
    logic tgl_d;
    logic tgl_q;

    pfd_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .ovf_i    (ovf_i),
        .sel_i    (src_sel_i),
        .strobe_o (sel_strobe)
    );

    pfd_toggle u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (fn_en_i),
        .strobe_i (sel_strobe),
        .tgl_d_o  (tgl_d),
        .tgl_q_o  (tgl_q)
    );

    pfd_pin_gate u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (fn_en_i),
        .tgl_next_i (tgl_d),
        .gate_i     (gate_i),
        .pins_o     (pin_o)
    );

endmodule

// File: rtl/pfd_tone_gen_chk.sv
module pfd_tone_gen_chk #(
    parameter int NUM_SRC = 2,
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] ovf_i,
    input logic [SEL_W-1:0]   src_sel_i,
    input logic               fn_en_i,
    input logic [1:0]         gate_i,
    input logic [1:0]         pin_o,
    input logic               tgl_q
);

    logic picked;
    always_comb begin
        picked = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_sel_i == SEL_W'(s)) picked = ovf_i[s];
        end
    end

    // R1: reset state
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_low: assert (pin_o == 2'b00 && tgl_q == 1'b0);
        end
    end

    a_r2_flip_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_en_i && picked) |=> (tgl_q != $past(tgl_q)));

    a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_en_i && !picked) |=> $stable(tgl_q));

    a_r4_never_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_o[0] && pin_o[1]));

    a_r4_phase_match: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_en_i && gate_i == 2'b11) |=> (pin_o == {~tgl_q, tgl_q}));

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_en_i |=> (pin_o == 2'b00 && tgl_q == 1'b0));

    a_r6_gate0_low: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i[0] |=> !pin_o[0]);

    a_r6_gate1_low: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i[1] |=> !pin_o[1]);

endmodule

bind pfd_tone_gen pfd_tone_gen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_i     (ovf_i),
    .src_sel_i (src_sel_i),
    .fn_en_i   (fn_en_i),
    .gate_i    (gate_i),
    .pin_o     (pin_o),
    .tgl_q     (tgl_q)
);

// File: tb/pfd_tone_gen_test.sv
`timescale 1ns/1ps
module pfd_tone_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ovf_i = '0;
    logic [0:0] src_sel_i = '0;
    logic       fn_en_i = 1'b0;
    logic [1:0] gate_i = '0;
    logic [1:0] pin_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic m_tgl = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfd_tone_gen #(.NUM_SRC(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_i     (ovf_i),
        .src_sel_i (src_sel_i),
        .fn_en_i   (fn_en_i),
        .gate_i    (gate_i),
        .pin_o     (pin_o)
    );

    function automatic logic next_tgl(logic cur, logic en, logic [1:0] ovf, logic sel);
        if (!en) return 1'b0;
        return ovf[sel] ? ~cur : cur;
    endfunction

    function automatic logic [1:0] pins_of(logic t, logic en, logic [1:0] g);
        return {en & g[1] & ~t, en & g[0] & t};
    endfunction

    task automatic check(string req, logic [1:0] exp);
        compared++;
        if (pin_o !== exp) begin
            mismatched++;
            $display("FAIL %s: pin_o=%b expected=%b", req, pin_o, exp);
        end
    endtask

    // Drive inputs at negedge, model one edge, compare at the next negedge
    task automatic step(logic [1:0] ovf, logic sel, logic en, logic [1:0] g, string req);
        ovf_i = ovf; src_sel_i = sel; fn_en_i = en; gate_i = g;
        @(posedge clk);
        m_tgl = next_tgl(m_tgl, en, ovf, sel);
        @(negedge clk);
        check(req, pins_of(m_tgl, en, g));
    endtask

    function automatic string tag_of(logic [1:0] ovf, logic sel, logic en, logic [1:0] g);
        if (!en) return "R5";
        if (g != 2'b11) return "R6";
        if (ovf[sel]) return "R2";
        if (ovf[~sel]) return "R3";
        return "R4";
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: cycles=%0d expected=<50000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", 2'b00);
        rst_n = 1'b1;
        m_tgl = 1'b0;

        // R5 re-enable: inverse phase high first
        step(2'b00, 1'b0, 1'b1, 2'b11, "R5");
        // R2 toggles on selected strobe
        step(2'b01, 1'b0, 1'b1, 2'b11, "R2");
        step(2'b01, 1'b0, 1'b1, 2'b11, "R2");
        // R3 other timer ignored
        step(2'b10, 1'b0, 1'b1, 2'b11, "R3");
        step(2'b10, 1'b0, 1'b1, 2'b11, "R3");
        // R7 switch to timer 1 with a strobe from it at the same edge
        step(2'b10, 1'b1, 1'b1, 2'b11, "R7");
        step(2'b01, 1'b1, 1'b1, 2'b11, "R7");
        // R8 held strobe toggles every edge
        for (int k = 0; k < 5; k++) step(2'b10, 1'b1, 1'b1, 2'b11, "R8");
        // R6 gate pin 0 off while toggle keeps advancing
        step(2'b10, 1'b1, 1'b1, 2'b10, "R6");
        step(2'b10, 1'b1, 1'b1, 2'b10, "R6");
        step(2'b00, 1'b1, 1'b1, 2'b01, "R6");
        step(2'b00, 1'b1, 1'b1, 2'b11, "R6");
        // R5 disable clears, strobes ignored
        step(2'b11, 1'b1, 1'b0, 2'b11, "R5");
        step(2'b11, 1'b0, 1'b0, 2'b11, "R5");
        step(2'b00, 1'b0, 1'b1, 2'b11, "R5");

        for (int i = 0; i < 3000; i++) begin
            logic [1:0] ovf = 2'($urandom);
            logic sel = 1'($urandom);
            logic en = ($urandom % 8) != 0;
            logic [1:0] g = (($urandom % 4) == 0) ? 2'($urandom) : 2'b11;
            step(ovf, sel, en, g, tag_of(ovf, sel, en, g));
        end

        // R1 reset in mid-run
        rst_n = 1'b0;
        m_tgl = 1'b0;
        #1;
        check("R1", 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b00, 1'b0, 1'b1, 2'b11, "R1");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule